// File: doc/BRIEF.md
# IN Endpoint Interrupt Status Aggregator

This block keeps the interrupt status of the IN endpoints of a USB device controller and rolls it up for software. The endpoint logic sends single-cycle event strobes for each endpoint: transfer done, endpoint turned off, IN timeout, IN token while the transmit FIFO was empty, and NAK now in force. Each strobe sets a sticky flag that stays set until software writes a one to that flag's bit position. One status bit is not stored. It is computed each cycle from the endpoint's transmit FIFO free-space count. A global select chooses whether that bit means "at least half empty" or "completely empty".

Each endpoint's status word feeds a summary bit, and the summary bits feed one global IN interrupt line. Clearing the last active cause in an endpoint word therefore drops that endpoint's summary bit and, if no other endpoint is active, the global line in the same cycle. Software uses a simple request port: a read returns its data on the cycle after the request, and a write acts on the clock edge at which it is presented.

The register-port controller is a two-state machine. `RP_IDLE` (no read data pending) moves to `RP_RESP` on a read request (transition *read-accept*). `RP_RESP` (read data valid) stays in `RP_RESP` on a back-to-back read (*read-chain*) and returns to `RP_IDLE` otherwise (*read-done*). `RP_IDLE` stays in `RP_IDLE` when there is no read (*idle-hold*).

Top module: `epi_irq_agg`

## Requirements
- R1: After reset every sticky flag is clear. With a FIFO free count equal to the FIFO depth, an endpoint status word reads 0x00000080.
- R2: A strobe on an endpoint sets that endpoint's flag at the matching bit, and the flag stays set. The bit positions are: transfer done bit 0, endpoint off bit 1, timeout bit 3, token-on-empty bit 4, NAK in force bit 6.
- R3: A write to a status word clears each flag whose bit is written as 1. A bit written as 0 has no effect. Writes to bit 7 and to reserved bits have no effect.
- R4: Bit 7 is live. With `cfg_empty_full`=0 it is 1 when the free count is at least DEPTH/2. With `cfg_empty_full`=1 it is 1 only when the free count equals DEPTH.
- R5: A pulse on `cmd_clr_nak[n]` clears bit 6 of endpoint n.
- R6: When a set strobe and a clear (a write of 1 or a clear-NAK command) hit the same flag in the same cycle, the flag ends up set.
- R7: The timeout flag can be set only on endpoint 0. Timeout strobes on other endpoints are ignored.
- R8: The token-on-empty flag is not set on an endpoint whose `ep_periodic` bit is 1.
- R9: `in_summary[n]` is the OR of endpoint n's status bits, including the live bit 7. The summary word at address 0x818 holds `in_summary` in bits NUM_EP-1:0. Reading it, or writing to it, changes nothing.
- R10: `in_irq` is high exactly when any summary bit is high.
- R11: A read request gives `rd_valid`=1 on the next cycle with the data. Unmapped addresses read 0. Bits 31:8, 5 and 2 of a status word read 0.
- R12: Endpoint n's status word sits at address 0x908 + n*0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_xfer_done | input | NUM_EP | Transfer-done strobe per endpoint |
| ev_ep_off | input | NUM_EP | Endpoint-off strobe per endpoint |
| ev_timeout | input | NUM_EP | IN timeout strobe per endpoint |
| ev_tok_empty | input | NUM_EP | IN-token-on-empty-FIFO strobe per endpoint |
| ev_nak_eff | input | NUM_EP | NAK-in-force strobe per endpoint |
| cmd_clr_nak | input | NUM_EP | Clear-NAK command per endpoint |
| ep_periodic | input | NUM_EP | 1 marks a periodic endpoint |
| fifo_free | input | NUM_EP*FREE_W | Free-space count per endpoint FIFO, endpoint n at bits n*FREE_W upward |
| cfg_empty_full | input | 1 | 0: half-empty threshold; 1: completely-empty threshold |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Register byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| in_summary | output | NUM_EP | Per-endpoint summary bits |
| in_irq | output | 1 | Global IN endpoint interrupt |

## Verification
A flag that is stored wrongly shows up on `in_summary` and `in_irq` at the first clock edge after the strobe or the clear. It then shows in the read data one cycle after any read of that endpoint's word. A fault in the threshold compare appears on the same cycle as the change in the free count, because bit 7 passes through no register before reaching the summary. A fault in the port state machine shows as a `rd_valid` pulse that arrives late, arrives twice, or never arrives after a read request.

// File: rtl/epi_pkg.sv
package epi_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] STAT_BASE   = 12'h908;
    localparam logic [ADDR_W-1:0] STAT_STRIDE = 12'h020;
    localparam logic [ADDR_W-1:0] SUM_ADDR    = 12'h818;

    // Bit positions of the status word
    localparam int B_DONE = 0;
    localparam int B_OFF  = 1;
    localparam int B_TMO  = 3;
    localparam int B_TOK  = 4;
    localparam int B_NAK  = 6;
    localparam int B_LVL  = 7;

    typedef struct packed {
        logic nak;
        logic tok;
        logic tmo;
        logic off;
        logic done;
    } ep_flags_t;

    typedef enum logic [0:0] {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rp_state_t;

    function automatic logic [ADDR_W-1:0] stat_addr(input int ep);
        return STAT_BASE + STAT_STRIDE * ADDR_W'(ep);
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input ep_flags_t f, input logic lvl);
        logic [REG_W-1:0] w;
        w         = '0;
        w[B_DONE] = f.done;
        w[B_OFF]  = f.off;
        w[B_TMO]  = f.tmo;
        w[B_TOK]  = f.tok;
        w[B_NAK]  = f.nak;
        w[B_LVL]  = lvl;
        return w;
    endfunction

    function automatic ep_flags_t flags_of_word(input logic [7:0] w);
        ep_flags_t f;
        f.done = w[B_DONE];
        f.off  = w[B_OFF];
        f.tmo  = w[B_TMO];
        f.tok  = w[B_TOK];
        f.nak  = w[B_NAK];
        return f;
    endfunction
endpackage

// File: rtl/epi_ep_status.sv
module epi_ep_status
    import epi_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ev_done,
    input  logic      ev_off,
    input  logic      ev_tmo,
    input  logic      ev_tok,
    input  logic      ev_nak,
    input  logic      periodic,
    input  logic      clr_nak_cmd,
    input  ep_flags_t clr_w,
    output ep_flags_t flags
);
    ep_flags_t set_v;
    ep_flags_t clr_v;

    always_comb begin
        set_v.done = ev_done;
        set_v.off  = ev_off;
        set_v.tmo  = IS_CTRL & ev_tmo;
        set_v.tok  = ev_tok & ~periodic;
        set_v.nak  = ev_nak;
        clr_v      = clr_w;
        clr_v.nak  = clr_w.nak | clr_nak_cmd;
    end

    // A set strobe wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= ep_flags_t'((flags & ~clr_v) | set_v);
        end
    end
endmodule

// File: rtl/epi_fifo_level.sv
module epi_fifo_level #(
    parameter int DEPTH  = 16,
    parameter int FREE_W = $clog2(DEPTH + 1)
) (
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              full_only,
    output logic              lvl
);
    localparam logic [FREE_W-1:0] HALF_CNT = FREE_W'(DEPTH / 2);
    localparam logic [FREE_W-1:0] FULL_CNT = FREE_W'(DEPTH);

    always_comb begin
        if (full_only) begin
            lvl = (free_cnt >= FULL_CNT);
        end else begin
            lvl = (free_cnt >= HALF_CNT);
        end
    end
endmodule

// File: rtl/epi_regport.sv
module epi_regport
    import epi_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [REG_W-1:0]             req_wdata,
    input  logic [NUM_EP-1:0][REG_W-1:0] stat_words,
    input  logic [NUM_EP-1:0]            summary,
    output ep_flags_t [NUM_EP-1:0]       wr_clr,
    output logic                         rd_valid,
    output logic [REG_W-1:0]             rd_data
);
    rp_state_t         state_q;
    rp_state_t         state_d;
    logic [NUM_EP-1:0] ep_hit;
    logic              sum_hit;
    logic              rd_req;
    logic              wr_req;
    logic [REG_W-1:0]  rd_next;
    logic [REG_W-1:0]  rd_q;
    logic              wdata_unused;

    assign wdata_unused = ^req_wdata[REG_W-1:8];
    assign sum_hit      = (req_addr == SUM_ADDR);
    assign rd_req       = req_valid & ~req_write;
    assign wr_req       = req_valid & req_write;

    always_comb begin
        for (int e = 0; e < NUM_EP; e++) begin
            ep_hit[e] = (req_addr == stat_addr(e));
        end
    end

    always_comb begin
        rd_next = '0;
        if (sum_hit) begin
            rd_next[NUM_EP-1:0] = summary;
        end
        for (int e = 0; e < NUM_EP; e++) begin
            if (ep_hit[e]) begin
                rd_next = stat_words[e];
            end
        end
    end

    always_comb begin
        for (int e = 0; e < NUM_EP; e++) begin
            wr_clr[e] = (wr_req && ep_hit[e]) ? flags_of_word(req_wdata[7:0]) : '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (state_q)
            RP_IDLE: state_d = rd_req ? RP_RESP : RP_IDLE;
            RP_RESP: state_d = rd_req ? RP_RESP : RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_req) begin
            rd_q <= rd_next;
        end
    end

    // Outputs
    always_comb begin
        rd_valid = (state_q == RP_RESP);
        rd_data  = rd_valid ? rd_q : '0;
    end
endmodule

// File: rtl/epi_irq_agg.sv
module epi_irq_agg
    import epi_pkg::*;
#(
    parameter int NUM_EP     = 4,
    parameter int FIFO_DEPTH = 16,
    localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EP-1:0]        ev_xfer_done,
    input  logic [NUM_EP-1:0]        ev_ep_off,
    input  logic [NUM_EP-1:0]        ev_timeout,
    input  logic [NUM_EP-1:0]        ev_tok_empty,
    input  logic [NUM_EP-1:0]        ev_nak_eff,
    input  logic [NUM_EP-1:0]        cmd_clr_nak,
    input  logic [NUM_EP-1:0]        ep_periodic,
    input  logic [NUM_EP*FREE_W-1:0] fifo_free,
    input  logic                     cfg_empty_full,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [11:0]              req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    output logic [NUM_EP-1:0]        in_summary,
    output logic                     in_irq
);
    ep_flags_t [NUM_EP-1:0]       flags;
    ep_flags_t [NUM_EP-1:0]       wr_clr;
    logic [NUM_EP-1:0]            lvl;
    logic [NUM_EP-1:0][REG_W-1:0] stat_words;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        epi_ep_status #(
            .IS_CTRL (g == 0)
        ) u_stat (
            .clk         (clk),
            .rst_n       (rst_n),
            .ev_done     (ev_xfer_done[g]),
            .ev_off      (ev_ep_off[g]),
            .ev_tmo      (ev_timeout[g]),
            .ev_tok      (ev_tok_empty[g]),
            .ev_nak      (ev_nak_eff[g]),
            .periodic    (ep_periodic[g]),
            .clr_nak_cmd (cmd_clr_nak[g]),
            .clr_w       (wr_clr[g]),
            .flags       (flags[g])
        );

        epi_fifo_level #(
            .DEPTH  (FIFO_DEPTH),
            .FREE_W (FREE_W)
        ) u_lvl (
            .free_cnt  (fifo_free[g*FREE_W +: FREE_W]),
            .full_only (cfg_empty_full),
            .lvl       (lvl[g])
        );

        assign stat_words[g] = pack_status(flags[g], lvl[g]);
        assign in_summary[g] = (|flags[g]) | lvl[g];
    end

    assign in_irq = |in_summary;

    epi_regport #(
        .NUM_EP (NUM_EP)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .stat_words (stat_words),
        .summary    (in_summary),
        .wr_clr     (wr_clr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/epi_irq_agg_chk.sv
module epi_irq_agg_chk
    import epi_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] ev_xfer_done,
    input logic [NUM_EP-1:0] ev_ep_off,
    input logic [NUM_EP-1:0] ev_nak_eff,
    input logic              req_valid,
    input logic              req_write,
    input logic [11:0]       req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [NUM_EP-1:0] in_summary,
    input logic              in_irq
);
    for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
        assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ev_xfer_done[g] |=> in_summary[g]);
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ev_nak_eff[g] |=> in_summary[g]);
    end

    assert_irq_rollup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ep_off != '0) |=> in_irq);

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_no_spurious_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr) != SUM_ADDR) |->
            (rd_data[31:8] == 24'h0 && !rd_data[5] && !rd_data[2]));

    assert_tmo_ep0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_data[3] && $past(req_addr) != SUM_ADDR) |->
            ($past(req_addr) == STAT_BASE));
endmodule

bind epi_irq_agg epi_irq_agg_chk #(
    .NUM_EP (NUM_EP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_xfer_done (ev_xfer_done),
    .ev_ep_off    (ev_ep_off),
    .ev_nak_eff   (ev_nak_eff),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .in_summary   (in_summary),
    .in_irq       (in_irq)
);

// File: tb/tb_epi_irq_agg.sv
module tb_epi_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NEP   = 4;
    localparam int DEPTH = 16;
    localparam int FW    = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NEP-1:0]    ev_xfer_done = '0, ev_ep_off = '0, ev_timeout = '0;
    logic [NEP-1:0]    ev_tok_empty = '0, ev_nak_eff = '0, cmd_clr_nak = '0;
    logic [NEP-1:0]    ep_periodic = 4'b1000;
    logic [NEP*FW-1:0] fifo_free;
    logic              cfg_empty_full = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [NEP-1:0]    in_summary;
    logic              in_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    epi_irq_agg #(.NUM_EP(NEP), .FIFO_DEPTH(DEPTH)) dut (.*);

    function automatic logic [11:0] ep_addr(input int e);
        return 12'h908 + 12'h020 * 12'(e);
    endfunction

    // Monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected read data: actual %h expected none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic ev(input logic [NEP-1:0] dn, input logic [NEP-1:0] of, input logic [NEP-1:0] tm,
                      input logic [NEP-1:0] tk, input logic [NEP-1:0] nk, input logic [NEP-1:0] cl);
        @(negedge clk);
        ev_xfer_done = dn; ev_ep_off = of; ev_timeout = tm;
        ev_tok_empty = tk; ev_nak_eff = nk; cmd_clr_nak = cl;
        @(negedge clk);
        ev_xfer_done = '0; ev_ep_off = '0; ev_timeout = '0;
        ev_tok_empty = '0; ev_nak_eff = '0; cmd_clr_nak = '0;
    endtask

    task automatic chk_sum(input logic [NEP-1:0] e, input string t);
        n_checks++;
        if (in_summary !== e || in_irq !== (e != '0)) begin
            n_fail++;
            $display("FAIL %s summary/irq: actual %b/%b expected %b/%b", t, in_summary, in_irq, e, e != '0);
        end
    endtask

    task automatic set_free(input int e, input int v);
        fifo_free[e*FW +: FW] = FW'(v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int e = 0; e < NEP; e++) set_free(e, DEPTH);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R12: reset value at each endpoint address
        chk_sum(4'b1111, "R1");
        for (int e = 0; e < NEP; e++) rd(ep_addr(e), 32'h80, "R1 R12");
        rd(12'h818, 32'h0000000F, "R9");
        // FIFOs full: live bit drops
        for (int e = 0; e < NEP; e++) set_free(e, 0);
        @(negedge clk);
        chk_sum(4'b0000, "R10");
        rd(ep_addr(0), 32'h0, "R4");
        // R4: threshold modes on ep1
        set_free(1, DEPTH/2);      rd(ep_addr(1), 32'h80, "R4 half at boundary");
        set_free(1, DEPTH/2 - 1);  rd(ep_addr(1), 32'h00, "R4 half below");
        cfg_empty_full = 1'b1;
        set_free(1, DEPTH - 1);    rd(ep_addr(1), 32'h00, "R4 full below");
        set_free(1, DEPTH);        rd(ep_addr(1), 32'h80, "R4 full at depth");
        set_free(1, 0);
        cfg_empty_full = 1'b0;
        // R2: sticky sets
        ev(4'b0100, '0, '0, '0, '0, '0);
        chk_sum(4'b0100, "R2");
        rd(ep_addr(2), 32'h01, "R2 done");
        ev('0, 4'b0100, '0, '0, 4'b0100, '0);
        rd(ep_addr(2), 32'h43, "R2 off+nak");
        // R3: write-one clear
        wr(ep_addr(2), 32'h82);    rd(ep_addr(2), 32'h41, "R3 clear bit1");
        wr(ep_addr(2), 32'h00);    rd(ep_addr(2), 32'h41, "R3 zero write");
        wr(ep_addr(2), 32'hFFFFFFFF);
        chk_sum(4'b0000, "R3 R9");
        rd(ep_addr(2), 32'h00, "R3 clear all");
        // R7: timeout only endpoint 0
        ev('0, '0, 4'b1111, '0, '0, '0);
        chk_sum(4'b0001, "R7");
        rd(ep_addr(0), 32'h08, "R7 ep0");
        rd(ep_addr(1), 32'h00, "R7 ep1");
        wr(ep_addr(0), 32'h08);
        // R8: token-on-empty skipped for periodic endpoint 3
        ev('0, '0, '0, 4'b1010, '0, '0);
        rd(ep_addr(1), 32'h10, "R8 ep1");
        rd(ep_addr(3), 32'h00, "R8 ep3 periodic");
        wr(ep_addr(1), 32'h10);
        // R5: clear-NAK command
        ev('0, '0, '0, '0, 4'b0010, '0);
        rd(ep_addr(1), 32'h40, "R5 set");
        ev('0, '0, '0, '0, '0, 4'b0010);
        rd(ep_addr(1), 32'h00, "R5 cleared");
        // R6: set wins against clear-NAK and against write-one
        ev('0, '0, '0, '0, 4'b0001, 4'b0001);
        rd(ep_addr(0), 32'h40, "R6 nak vs cmd");
        @(negedge clk);
        ev_xfer_done = 4'b0001;
        req_valid = 1'b1; req_write = 1'b1; req_addr = ep_addr(0); req_wdata = 32'h41;
        @(negedge clk);
        ev_xfer_done = '0; req_valid = 1'b0; req_write = 1'b0;
        rd(ep_addr(0), 32'h01, "R6 done vs write");
        // R9: summary word reads and writes have no side effects
        rd(12'h818, 32'h1, "R9 first");
        rd(12'h818, 32'h1, "R9 second");
        wr(12'h818, 32'hFFFFFFFF);
        rd(12'h818, 32'h1, "R9 after write");
        chk_sum(4'b0001, "R9 R10");
        // R11: unmapped addresses
        rd(12'h904, 32'h0, "R11 unmapped");
        rd(ep_addr(5), 32'h0, "R11 beyond last ep");
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing reads: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule